// File: doc/BRIEF.md
# Host Bus Byte Mailbox with FIFO Channels

This block is a byte-wide slave on a simple host bus that gives a host computer a mailbox into an embedded controller. The host sees four byte registers at offsets 0 to 3. A data register and a status register form the main channel, and a second pair forms the secondary channel used for data records. Each channel has a 16-entry FIFO in each direction. In the host-to-controller direction, host writes fill the FIFO and the controller drains it through a valid/ready port. In the controller-to-host direction, the controller fills the FIFO through a valid/ready port and host reads drain it.

The host polls before every byte it moves. Status bit 5 is an active-low flag that says a byte is waiting. Status bit 6 says the inbound FIFO is full. Both FIFOs of a channel can be emptied only by a fixed unlock pattern on that channel's status register. The pattern is a read, then writes of 0x01, 0x80, 0x01 and 0x80, then a closing read. Any other host access in the middle of the pattern abandons it.

Top module: `hbmb_top`

## Requirements
- R1: A host write to offset 0 (or 2) enqueues the byte for the main (or secondary) controller output port. A host read of offset 0 (or 2) returns and dequeues the oldest byte pushed by the controller on that channel. Bytes leave each FIFO in the order they entered.
- R2: Bit 5 of the status register at offset 1 (or 3) reads 0 while the controller-to-host FIFO of that channel holds at least one byte, and reads 1 while it is empty.
- R3: Bit 6 of the status register reads 1 while the host-to-controller FIFO of that channel holds 16 bytes, and reads 0 otherwise.
- R4: A status read in the cycle right after a push or a pop already reflects that push or pop.
- R5: A host write to a full FIFO is dropped, and the stored bytes are unchanged. The controller-side ready output is low while the controller-to-host FIFO is full, and a push offered then is dropped.
- R6: A host read of an empty data register returns 0x00 and consumes nothing. A byte pushed afterwards is the next one returned.
- R7: The unlock pattern on a channel's status register empties both FIFOs of that channel. The pattern is a read, then writes of 0x01, 0x80, 0x01, 0x80, then a read. The closing read still returns the status from before the clear. From the next cycle the status reads 0x20 and the controller output valid is low.
- R8: Any host access that does not match the next step of the pattern abandons it, and the FIFOs are not cleared. A read of the status register at any step starts the pattern again at its first step.
- R9: Status bits other than 5 and 6 read 0, and writes to a status register do not change its value. The read data bus is 0x00 whenever no read is strobed.
- R10: The two channels are independent. Traffic on one channel, and a clear of one channel, leave the other channel's contents and status unchanged.
- R11: After reset every FIFO is empty, both status registers read 0x20, and both controller output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wr | input | 1 | Write strobe, one cycle per byte (wins over host_rd) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle host_rd is high |
| main_dn_valid | output | 1 | Main host-to-controller byte available |
| main_dn_data | output | 8 | Main host-to-controller byte |
| main_dn_ready | input | 1 | Controller takes the main byte |
| main_up_valid | input | 1 | Controller offers a main response byte |
| main_up_data | input | 8 | Main response byte |
| main_up_ready | output | 1 | Main response FIFO has room |
| sec_dn_valid | output | 1 | Secondary host-to-controller byte available |
| sec_dn_data | output | 8 | Secondary host-to-controller byte |
| sec_dn_ready | input | 1 | Controller takes the secondary byte |
| sec_up_valid | input | 1 | Controller offers a record byte |
| sec_up_data | input | 8 | Record byte |
| sec_up_ready | output | 1 | Record FIFO has room |

## Verification
If a FIFO count goes wrong, the status bits show it on the very next status poll: bit 5 or bit 6 holds the wrong value one cycle after the push or pop that caused it. A wrong pointer shows up as a reordered, repeated or missing byte on the next read or controller pop. A stray 0x00 from an empty read points to a pop that moved the read pointer. A fault in the unlock tracker shows in one of two ways. Either the status still reports data after a correct pattern, or a broken or interleaved pattern loses bytes, which shows on the first status read after the closing access.

// File: rtl/hbmb_pkg.sv
// Package: shared constants for the host bus byte mailbox.
// Assumes a byte-wide host bus with two channels of two registers each.
package hbmb_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_CH    = 2;
    localparam int BIT_RXRDY = 5;   // active-low "byte waiting" flag
    localparam int BIT_TXFUL = 6;   // "inbound FIFO full" flag
    localparam logic [BYTE_W-1:0] KEY_A = 8'h01;
    localparam logic [BYTE_W-1:0] KEY_B = 8'h80;

    typedef enum logic [2:0] {
        UL_IDLE,
        UL_OPEN,    // read seen, expect KEY_A
        UL_A1,      // expect KEY_B
        UL_B1,      // expect KEY_A
        UL_A2,      // expect KEY_B
        UL_ARMED    // expect closing read
    } unlock_t;
endpackage

// File: rtl/hbmb_fifo.sv
// Module: hbmb_fifo
// Synchronous single-clock FIFO. A push when full and a pop when empty are
// dropped. Clear empties it and wins over a push or pop in the same cycle.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module hbmb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current occupancy.
    always_comb begin
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        head    = mem[rptr];
    end

    // Store the pushed byte.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R5
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clr |=> full && $stable(wptr)); // R5
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !clr |=> empty && $stable(rptr)); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty); // R7
endmodule

// File: rtl/hbmb_unlock.sv
// Module: hbmb_unlock
// Tracks the clear pattern on one channel's status register. The pattern is
// a read, then KEY_A, KEY_B, KEY_A, KEY_B writes, then a read. Any other host
// access returns to idle, and a status read restarts the pattern. Assumes
// acc_rd is already masked when a write is strobed in the same cycle.
module hbmb_unlock
    import hbmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              is_ctl,
    input  logic [BYTE_W-1:0] wdata,
    output logic              clear_o
);
    unlock_t st;
    unlock_t st_nx;
    logic    rd_ctl;
    logic    wr_ctl;
    logic    acc;

    // Next-state selection for the pattern tracker.
    always_comb begin
        rd_ctl  = acc_rd && is_ctl;
        wr_ctl  = acc_wr && is_ctl;
        acc     = acc_rd || acc_wr;
        clear_o = 1'b0;
        st_nx   = st;
        if (acc) st_nx = rd_ctl ? UL_OPEN : UL_IDLE;
        case (st)
            UL_OPEN:  if (wr_ctl && wdata == KEY_A) st_nx = UL_A1;
            UL_A1:    if (wr_ctl && wdata == KEY_B) st_nx = UL_B1;
            UL_B1:    if (wr_ctl && wdata == KEY_A) st_nx = UL_A2;
            UL_A2:    if (wr_ctl && wdata == KEY_B) st_nx = UL_ARMED;
            UL_ARMED: if (rd_ctl) begin
                clear_o = 1'b1;
                st_nx   = UL_IDLE;
            end
            default: ;
        endcase
    end

    // Hold the tracker state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= UL_IDLE;
        else        st <= st_nx;
    end

    AST_SEQ_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !is_ctl |=> st == UL_IDLE); // R8
    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl && st != UL_ARMED |=> st == UL_OPEN); // R8
endmodule

// File: rtl/hbmb_top.sv
// Module: hbmb_top
// Byte-wide host bus slave with two mailbox channels. Offsets 0/1 are the
// main data/status pair and 2/3 the secondary pair. Each channel has one FIFO
// per direction and its own clear-pattern tracker. Assumes one host strobe
// per byte; a write strobe wins over a read strobe in the same cycle.
module hbmb_top
    import hbmb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              main_dn_valid,
    output logic [BYTE_W-1:0] main_dn_data,
    input  logic              main_dn_ready,
    input  logic              main_up_valid,
    input  logic [BYTE_W-1:0] main_up_data,
    output logic              main_up_ready,
    output logic              sec_dn_valid,
    output logic [BYTE_W-1:0] sec_dn_data,
    input  logic              sec_dn_ready,
    input  logic              sec_up_valid,
    input  logic [BYTE_W-1:0] sec_up_data,
    output logic              sec_up_ready
);
    logic              rd_eff;
    logic [NUM_CH-1:0] dn_ready_a;
    logic [NUM_CH-1:0] up_valid_a;
    logic [NUM_CH-1:0] dn_empty;
    logic [NUM_CH-1:0] dn_full;
    logic [NUM_CH-1:0] up_empty;
    logic [NUM_CH-1:0] up_full;
    logic [NUM_CH-1:0] ch_clear;
    logic [BYTE_W-1:0] up_data_a [NUM_CH];
    logic [BYTE_W-1:0] dn_head   [NUM_CH];
    logic [BYTE_W-1:0] up_head   [NUM_CH];
    logic [BYTE_W-1:0] status    [NUM_CH];

    // Gather the per-channel controller inputs into arrays.
    always_comb begin
        rd_eff       = host_rd && !host_wr;
        dn_ready_a   = {sec_dn_ready, main_dn_ready};
        up_valid_a   = {sec_up_valid, main_up_valid};
        up_data_a[0] = main_up_data;
        up_data_a[1] = sec_up_data;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        logic data_wr;
        logic data_rd;

        // Decode this channel's register pair.
        always_comb begin
            hit     = (host_addr[1] == 1'(c));
            data_wr = host_wr && hit && !host_addr[0];
            data_rd = rd_eff && hit && !host_addr[0];
            status[c] = '0;
            status[c][BIT_RXRDY] = up_empty[c];
            status[c][BIT_TXFUL] = dn_full[c];
        end

        hbmb_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_dn (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ch_clear[c]),
            .push  (data_wr),
            .din   (host_wdata),
            .pop   (dn_ready_a[c]),
            .head  (dn_head[c]),
            .empty (dn_empty[c]),
            .full  (dn_full[c])
        );

        hbmb_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_up (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ch_clear[c]),
            .push  (up_valid_a[c]),
            .din   (up_data_a[c]),
            .pop   (data_rd),
            .head  (up_head[c]),
            .empty (up_empty[c]),
            .full  (up_full[c])
        );

        hbmb_unlock u_unlock (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_rd  (rd_eff),
            .acc_wr  (host_wr),
            .is_ctl  (hit && host_addr[0]),
            .wdata   (host_wdata),
            .clear_o (ch_clear[c])
        );
    end

    // Drive the controller-side handshake outputs.
    always_comb begin
        main_dn_valid = !dn_empty[0];
        main_dn_data  = dn_head[0];
        main_up_ready = !up_full[0];
        sec_dn_valid  = !dn_empty[1];
        sec_dn_data   = dn_head[1];
        sec_up_ready  = !up_full[1];
    end

    // Read data mux; empty data registers and idle cycles return zero.
    always_comb begin
        host_rdata = '0;
        if (rd_eff) begin
            if (host_addr[0])
                host_rdata = status[host_addr[1]];
            else if (!up_empty[host_addr[1]])
                host_rdata = up_head[host_addr[1]];
        end
    end

    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eff && host_addr[0] |-> (host_rdata & 8'h9F) == 8'h00); // R9
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eff && !host_addr[0] && up_empty[host_addr[1]] |-> host_rdata == 8'h00); // R6
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == 8'h00); // R9
endmodule

// File: tb/hbmb_top_tb.sv
`timescale 1ns/1ps
module hbmb_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       main_dn_valid, main_up_ready, sec_dn_valid, sec_up_ready;
    logic [7:0] main_dn_data, sec_dn_data;
    logic       main_dn_ready = 1'b0, sec_dn_ready = 1'b0;
    logic       main_up_valid = 1'b0, sec_up_valid = 1'b0;
    logic [7:0] main_up_data = '0, sec_up_data = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] q_dn0[$], q_dn1[$], q_up0[$], q_up1[$];

    always #2 clk = ~clk;

    hbmb_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .main_dn_valid(main_dn_valid), .main_dn_data(main_dn_data),
        .main_dn_ready(main_dn_ready), .main_up_valid(main_up_valid),
        .main_up_data(main_up_data), .main_up_ready(main_up_ready),
        .sec_dn_valid(sec_dn_valid), .sec_dn_data(sec_dn_data),
        .sec_dn_ready(sec_dn_ready), .sec_up_valid(sec_up_valid),
        .sec_up_data(sec_up_data), .sec_up_ready(sec_up_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Expected status byte from the bench's own queue model.
    function automatic logic [7:0] exp_stat(input int ch);
        int nd = (ch == 0) ? q_dn0.size() : q_dn1.size();
        int nu = (ch == 0) ? q_up0.size() : q_up1.size();
        return {1'b0, nd == 16, nu == 0, 5'b0};
    endfunction

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        if (a == 2'd0 && q_dn0.size() < 16) q_dn0.push_back(d);
        if (a == 2'd2 && q_dn1.size() < 16) q_dn1.push_back(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Read a data register and compare against the scoreboard.
    task automatic read_data(input int ch, input string req);
        logic [7:0] d, e;
        host_read(ch == 0 ? 2'd0 : 2'd2, d);
        if (ch == 0) e = (q_up0.size() != 0) ? q_up0.pop_front() : 8'h00;
        else         e = (q_up1.size() != 0) ? q_up1.pop_front() : 8'h00;
        chk(req, d, e);
    endtask

    task automatic read_stat(input int ch, input string req);
        logic [7:0] d;
        host_read(ch == 0 ? 2'd1 : 2'd3, d);
        chk(req, d, exp_stat(ch));
    endtask

    // Controller pushes one byte; ready must match the model's free space.
    task automatic ctl_push(input int ch, input logic [7:0] d);
        logic rdy;
        int   n;
        @(negedge clk);
        if (ch == 0) begin main_up_valid = 1'b1; main_up_data = d; end
        else         begin sec_up_valid = 1'b1;  sec_up_data = d;  end
        #1;
        rdy = (ch == 0) ? main_up_ready : sec_up_ready;
        n   = (ch == 0) ? q_up0.size() : q_up1.size();
        chk("R5 up_ready", {7'b0, rdy}, {7'b0, n < 16});
        if (n < 16) begin
            if (ch == 0) q_up0.push_back(d); else q_up1.push_back(d);
        end
        @(negedge clk);
        main_up_valid = 1'b0; sec_up_valid = 1'b0;
    endtask

    // Monitor: compares every byte the controller takes with the scoreboard.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && main_dn_ready && main_dn_valid) begin
            if (q_dn0.size() == 0) chk("R1 main unexpected byte", main_dn_data, 8'hxx);
            else chk("R1 main order", main_dn_data, q_dn0.pop_front());
        end
        if (rst_n && sec_dn_ready && sec_dn_valid) begin
            if (q_dn1.size() == 0) chk("R10 sec unexpected byte", sec_dn_data, 8'hxx);
            else chk("R10 sec order", sec_dn_data, q_dn1.pop_front());
        end
    end

    task automatic drain(input int ch);
        @(negedge clk);
        if (ch == 0) main_dn_ready = 1'b1; else sec_dn_ready = 1'b1;
        repeat (20) @(negedge clk);
        main_dn_ready = 1'b0; sec_dn_ready = 1'b0;
        #1;
        chk("R1 drained", 8'((ch == 0) ? q_dn0.size() : q_dn1.size()), 8'd0);
    endtask

    task automatic unlock(input logic [1:0] a, input string req);
        logic [7:0] d;
        logic [7:0] pre;
        pre = exp_stat(a[1]);
        host_read(a, d);
        host_write(a, 8'h01); host_write(a, 8'h80);
        host_write(a, 8'h01); host_write(a, 8'h80);
        host_read(a, d);
        chk(req, d, pre);
    endtask

    initial begin
        #(200000 * 4);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        #1 chk("R11 main_dn_valid", {7'b0, main_dn_valid}, 8'h00);
        chk("R11 sec_dn_valid", {7'b0, sec_dn_valid}, 8'h00);
        read_stat(0, "R11 main status");
        read_stat(1, "R11 sec status");

        // R2 R4: status right after each controller push, then reads
        ctl_push(0, 8'hA1);
        read_stat(0, "R2 R4 bit5 after push");
        ctl_push(0, 8'hA2); ctl_push(0, 8'hA3);
        read_data(0, "R1 read 1"); read_data(0, "R1 read 2");
        read_data(0, "R1 read 3");
        read_stat(0, "R4 bit5 after last pop");

        // R6 empty read consumes nothing
        read_data(0, "R6 empty read");
        ctl_push(0, 8'h5C);
        read_data(0, "R6 next byte after empty read");

        // R3 R5: fill host-to-controller FIFO, overflow dropped
        for (int i = 0; i < 15; i++) host_write(2'd0, 8'(8'h10 + i));
        read_stat(0, "R3 fifteen bytes not full");
        host_write(2'd0, 8'h1F);
        read_stat(0, "R3 full flag");
        host_write(2'd0, 8'hEE);
        read_stat(0, "R5 still full");
        drain(0);
        read_stat(0, "R3 not full after drain");

        // R5: controller side full protection
        for (int i = 0; i < 17; i++) ctl_push(0, 8'(8'h40 + i));
        for (int i = 0; i < 17; i++) read_data(0, "R5 R1 up order");

        // R10: secondary channel independent
        host_write(2'd2, 8'hC1); host_write(2'd2, 8'hC2);
        ctl_push(1, 8'hD1);
        read_stat(0, "R10 main unaffected");
        read_stat(1, "R10 sec status");
        read_data(1, "R10 sec read");
        drain(1);

        // R7: clear main while both directions hold data
        host_write(2'd0, 8'h71); host_write(2'd0, 8'h72);
        ctl_push(0, 8'h81); ctl_push(0, 8'h82);
        ctl_push(1, 8'h91);
        unlock(2'd1, "R7 closing read returns pre-clear status");
        q_dn0.delete(); q_up0.delete();
        #1 chk("R7 dn valid cleared", {7'b0, main_dn_valid}, 8'h00);
        read_stat(0, "R7 status after clear");
        read_data(0, "R7 empty after clear");
        read_stat(1, "R10 sec kept across main clear");
        read_data(1, "R10 sec byte kept");

        // R8: broken pattern does not clear
        ctl_push(0, 8'hB5);
        host_read(2'd1, d);
        host_write(2'd1, 8'h01); host_write(2'd1, 8'h55);
        host_write(2'd1, 8'h80); host_write(2'd1, 8'h01); host_write(2'd1, 8'h80);
        host_read(2'd1, d);
        read_stat(0, "R8 broken pattern keeps data");
        // R8: interleaved data access abandons it
        host_read(2'd1, d);
        host_write(2'd1, 8'h01); host_write(2'd1, 8'h80);
        host_write(2'd2, 8'hE1);
        host_write(2'd1, 8'h01); host_write(2'd1, 8'h80);
        host_read(2'd1, d);
        read_stat(0, "R8 interleaved access keeps data");
        drain(1);
        // R8: status read mid-pattern restarts it
        host_read(2'd1, d);
        host_write(2'd1, 8'h01);
        unlock(2'd1, "R8 restart closing read");
        q_up0.delete(); q_dn0.delete();
        read_stat(0, "R8 restarted pattern clears");

        // R9: status writes ignored, idle bus reads zero
        ctl_push(0, 8'h3C);
        host_write(2'd1, 8'hFF); host_write(2'd3, 8'hFF);
        read_stat(0, "R9 status write ignored");
        read_stat(1, "R9 sec status write ignored");
        @(negedge clk); #1;
        chk("R9 idle bus zero", host_rdata, 8'h00);
        read_data(0, "R9 data kept");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule